// File: doc/BRIEF.md
# Ping-Pong Audio Playback DMA

This block streams PCM audio from a circular buffer in memory towards a codec. Software programs a buffer base address, a length code and a sample format, then sets the run bit. The engine reads the buffer one 32-bit word at a time and turns every word into one or more stereo frames of two signed 16-bit values. Frames leave on a valid/ready port.

The buffer is treated as two equal halves. Finishing the first half raises a "half" status flag and moves the play position to the second half. Finishing the second half raises a "full" flag and wraps the position back to zero. Software refills whichever half has just been drained, so playback runs without gaps. Either flag can raise the interrupt line through its own enable bit.

Input samples may be 8-bit or 16-bit, mono or stereo. They are always widened to 16-bit stereo. The block also publishes the bit-clock rate the codec should run at, computed from a master-clock select bit and an 8-bit divider field.

Top module: `pcm_pingpong_dma`

## Requirements
- R1: After reset the mode, status, enable and position registers read zero, irq, mem_req and smp_valid are low, and bclk_rate is 176400.
- R2: Register offsets are:
  - 0x00: mode (read/write, 32 bits).
  - 0x18: divider (read/write, 32 bits).
  - 0x20: status (read-only flags). Bit 6 is the half flag and bit 7 is the full flag.
  - 0x24: interrupt enable (read/write, 32 bits).
  - 0x28: buffer base, bits 15:0 (write-only; reads return 0).
  - 0x2C: length code T (write-only; reads return 0).
  - 0x38: play position in bytes divided by 4 (read-only).
  - 0x40: buffer base, bits 31:16 (write-only; reads return 0).
- R3: The buffer holds (T+1)*4 bytes and each half holds (T+1)*2 bytes. T must be odd so that a half is a whole number of words. Word reads go to base + position + 4*k in order, where k counts the words within the current half. Only one read is outstanding at a time.
- R4: Completing the half that starts at position 0 sets status bit 6 and moves the position to (T+1)*2. Completing the other half sets status bit 7 and wraps the position to 0. Both flags stay set until they are cleared.
- R5: In 16-bit stereo mode (mode bit 0 = 1, bit 14 = 0), each word gives one frame: bits 15:0 go to left and bits 31:16 go to right.
- R6: In 16-bit mono mode (bit 0 = 1, bit 14 = 1), each word gives two frames: bits 15:0 first, then bits 31:16. Each value is copied to both channels.
- R7: In 8-bit stereo mode (bit 0 = 0, bit 14 = 0), each word gives two frames: byte 0 goes left and byte 1 goes right, then byte 2 goes left and byte 3 goes right. Each signed byte is multiplied by 256.
- R8: In 8-bit mono mode (bit 0 = 0, bit 14 = 1), each word gives four frames, bytes 0 to 3 in order. Each byte is multiplied by 256 and copied to both channels.
- R9: irq is high exactly when status AND enable is nonzero. Writing the status register clears each flag whose bit is written as 1. A flag being set in the same cycle takes priority over the clear.
- R10: bclk_rate equals M/64/(D+1), where M is 24576000 when mode bit 9 is set and 11289600 otherwise, and D is divider bits 15:8. The value is updated only by a write to the mode or divider register.
- R11: While mode bit 7 (run) is low, no memory read is requested and no frame is offered. A write that sets bit 7 when it was clear restarts playback at position 0 and word 0.
- R12: An offered frame stays valid with unchanged data until it is accepted, unless run drops first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| smp_valid | output | 1 | Frame offered |
| smp_ready | input | 1 | Sink accepts the frame |
| smp_left | output | 16 | Left sample |
| smp_right | output | 16 | Right sample |
| bclk_rate | output | 32 | Codec bit-clock rate in Hz |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the memory answers each accepted request with exactly one response. That response must arrive after the request is accepted and before run can be cleared and set again. They also assume T is not rewritten while playback is running.

The bench respects these assumptions:
- Its memory model returns data one cycle after acceptance.
- A disable and a re-enable are always separate register writes, so they lie at least two cycles apart.
- The length and base registers are written only while run is low.

Backpressure is applied on both the memory side (alternating ready) and the sample side (a credit counter). This exercises the hold and ordering rules.

// File: rtl/pcm_dma_pkg.sv
package pcm_dma_pkg;

  localparam int unsigned MCLK_FAST_HZ = 24576000;
  localparam int unsigned MCLK_SLOW_HZ = 11289600;
  localparam int unsigned OVERSAMPLE   = 64;

  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_DIV   = 8'h18;
  localparam logic [7:0] OFS_STAT  = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h24;
  localparam logic [7:0] OFS_BASEL = 8'h28;
  localparam logic [7:0] OFS_LEN   = 8'h2C;
  localparam logic [7:0] OFS_POS   = 8'h38;
  localparam logic [7:0] OFS_BASEH = 8'h40;

  localparam int MB_WIDE = 0;
  localparam int MB_RUN  = 7;
  localparam int MB_FAST = 9;
  localparam int MB_MONO = 14;
  localparam int SB_HALF = 6;
  localparam int SB_FULL = 7;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_WAIT, FS_EMIT} fetch_st_e;

  typedef struct packed {
    logic [15:0] left;
    logic [15:0] right;
  } frame_t;

  function automatic logic [2:0] frames_per_word(input logic wide, input logic mono);
    case ({wide, mono})
      2'b10:   return 3'd1;
      2'b01:   return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic frame_t unpack_frame(input logic [31:0] w, input logic [1:0] idx,
                                          input logic wide, input logic mono);
    frame_t f;
    logic [15:0] s;
    case ({wide, mono})
      2'b10: begin
        f.left  = w[15:0];
        f.right = w[31:16];
      end
      2'b11: begin
        s = idx[0] ? w[31:16] : w[15:0];
        f.left  = s;
        f.right = s;
      end
      2'b00: begin
        f.left  = {w[16*int'(idx[0]) +: 8], 8'h00};
        f.right = {w[16*int'(idx[0]) + 8 +: 8], 8'h00};
      end
      default: begin
        s = {w[8*int'(idx) +: 8], 8'h00};
        f.left  = s;
        f.right = s;
      end
    endcase
    return f;
  endfunction

  function automatic logic [31:0] bclk_rate_f(input logic fast, input logic [7:0] div);
    logic [31:0] m;
    m = fast ? 32'(MCLK_FAST_HZ) : 32'(MCLK_SLOW_HZ);
    return (m / 32'(OVERSAMPLE)) / ({24'd0, div} + 32'd1);
  endfunction

endpackage

// File: rtl/pcm_dma_regs.sv
module pcm_dma_regs
  import pcm_dma_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int TW = 16,
  parameter int PW = TW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          half_evt,
  input  logic          full_evt,
  input  logic [PW-1:0] play_pos,
  output logic          wide,
  output logic          mono,
  output logic          run,
  output logic          restart,
  output logic [31:0]   buf_base,
  output logic [TW-1:0] len_code,
  output logic          irq,
  output logic [31:0]   bclk_rate
);

  logic [DW-1:0] mode_q, div_q, ien_q, stat_vec;
  logic [15:0]   base_lo_q, base_hi_q;
  logic [TW-1:0] len_q;
  logic [1:0]    stat_q;
  logic [1:0]    clr_mask;
  logic          wr_mode, wr_div, wr_stat, wr_ien, wr_bl, wr_bh, wr_len;

  assign wr_mode = reg_wr && (reg_addr == AW'(OFS_MODE));
  assign wr_div  = reg_wr && (reg_addr == AW'(OFS_DIV));
  assign wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
  assign wr_ien  = reg_wr && (reg_addr == AW'(OFS_IEN));
  assign wr_bl   = reg_wr && (reg_addr == AW'(OFS_BASEL));
  assign wr_bh   = reg_wr && (reg_addr == AW'(OFS_BASEH));
  assign wr_len  = reg_wr && (reg_addr == AW'(OFS_LEN));

  assign restart  = wr_mode && reg_wdata[MB_RUN] && !mode_q[MB_RUN];
  assign clr_mask = wr_stat ? {reg_wdata[SB_FULL], reg_wdata[SB_HALF]} : 2'b00;

  always_comb begin
    stat_vec = '0;
    stat_vec[SB_HALF] = stat_q[0];
    stat_vec[SB_FULL] = stat_q[1];
  end

  assign wide     = mode_q[MB_WIDE];
  assign mono     = mode_q[MB_MONO];
  assign run      = mode_q[MB_RUN];
  assign buf_base = {base_hi_q, base_lo_q};
  assign len_code = len_q;
  assign irq      = |(stat_vec & ien_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      div_q     <= '0;
      ien_q     <= '0;
      stat_q    <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      len_q     <= '0;
      bclk_rate <= bclk_rate_f(1'b0, 8'd0);
    end else begin
      stat_q <= (stat_q & ~clr_mask) | {full_evt, half_evt};
      if (wr_mode) begin
        mode_q    <= reg_wdata;
        bclk_rate <= bclk_rate_f(reg_wdata[MB_FAST], div_q[15:8]);
      end
      if (wr_div) begin
        div_q     <= reg_wdata;
        bclk_rate <= bclk_rate_f(mode_q[MB_FAST], reg_wdata[15:8]);
      end
      if (wr_ien) ien_q     <= reg_wdata;
      if (wr_bl)  base_lo_q <= reg_wdata[15:0];
      if (wr_bh)  base_hi_q <= reg_wdata[15:0];
      if (wr_len) len_q     <= reg_wdata[TW-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      AW'(OFS_MODE): reg_rdata = mode_q;
      AW'(OFS_DIV):  reg_rdata = div_q;
      AW'(OFS_STAT): reg_rdata = stat_vec;
      AW'(OFS_IEN):  reg_rdata = ien_q;
      AW'(OFS_POS):  reg_rdata = DW'(play_pos >> 2);
      default:       reg_rdata = '0;
    endcase
  end

  AST_HALF_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat_q[0]) |-> $past(half_evt)); // R4
  AST_FULL_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat_q[1]) |-> $past(full_evt)); // R4
  AST_W1C_HALF: assert property (@(posedge clk) disable iff (!rst_n) (wr_stat && reg_wdata[SB_HALF] && !half_evt) |=> !stat_q[0]); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (stat_q != 2'b00)); // R9
  AST_RATE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_mode || wr_div) |=> $stable(bclk_rate)); // R10

endmodule

// File: rtl/pcm_dma_fetch.sv
module pcm_dma_fetch
  import pcm_dma_pkg::*;
#(
  parameter int MAW = 32,
  parameter int TW  = 16,
  parameter int PW  = TW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           restart,
  input  logic           wide,
  input  logic           mono,
  input  logic [MAW-1:0] buf_base,
  input  logic [TW-1:0]  len_code,
  output logic           mem_req,
  output logic [MAW-1:0] mem_addr,
  input  logic           mem_ready,
  input  logic           mem_rvalid,
  input  logic [31:0]    mem_rdata,
  output logic           smp_valid,
  input  logic           smp_ready,
  output logic [15:0]    smp_left,
  output logic [15:0]    smp_right,
  output logic [PW-1:0]  play_pos,
  output logic           half_evt,
  output logic           full_evt
);

  fetch_st_e     st_q;
  logic [31:0]   word_q;
  logic [1:0]    fidx_q;
  logic [TW-1:0] widx_q;
  logic [PW-1:0] pos_q;
  logic          wide_q, mono_q;

  logic [TW:0]   len_p1;
  logic [TW-1:0] blk_words;
  logic [PW-1:0] blk_bytes;
  logic [2:0]    fpw;
  logic          last_frame, last_word, accept, blk_end;
  frame_t        cur;

  assign len_p1    = {1'b0, len_code} + {{TW{1'b0}}, 1'b1};
  assign blk_words = (len_p1[TW:1] == '0) ? TW'(1) : len_p1[TW:1];
  assign blk_bytes = {len_p1, 1'b0};

  assign fpw        = frames_per_word(wide_q, mono_q);
  assign last_frame = ({1'b0, fidx_q} == (fpw - 3'd1));
  assign last_word  = (widx_q == (blk_words - TW'(1)));

  assign mem_req   = (st_q == FS_REQ) && run;
  assign mem_addr  = buf_base + MAW'(pos_q) + MAW'({widx_q, 2'b00});
  assign smp_valid = (st_q == FS_EMIT) && run;
  assign cur       = unpack_frame(word_q, fidx_q, wide_q, mono_q);
  assign smp_left  = cur.left;
  assign smp_right = cur.right;

  assign accept   = smp_valid && smp_ready;
  assign blk_end  = accept && last_frame && last_word;
  assign half_evt = blk_end && (pos_q == '0);
  assign full_evt = blk_end && (pos_q != '0);
  assign play_pos = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      word_q <= '0;
      fidx_q <= '0;
      widx_q <= '0;
      pos_q  <= '0;
      wide_q <= 1'b0;
      mono_q <= 1'b0;
    end else if (restart) begin
      st_q   <= FS_IDLE;
      fidx_q <= '0;
      widx_q <= '0;
      pos_q  <= '0;
    end else if (!run) begin
      st_q <= FS_IDLE;
    end else begin
      case (st_q)
        FS_IDLE: st_q <= FS_REQ;
        FS_REQ:  if (mem_ready) st_q <= FS_WAIT;
        FS_WAIT: if (mem_rvalid) begin
          word_q <= mem_rdata;
          wide_q <= wide;
          mono_q <= mono;
          fidx_q <= '0;
          st_q   <= FS_EMIT;
        end
        FS_EMIT: if (smp_ready) begin
          if (last_frame) begin
            st_q <= FS_REQ;
            if (last_word) begin
              widx_q <= '0;
              pos_q  <= (pos_q == '0) ? blk_bytes : '0;
            end else begin
              widx_q <= widx_q + TW'(1);
            end
          end else begin
            fidx_q <= fidx_q + 2'd1;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) !run |=> (!mem_req && !smp_valid)); // R11
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n) (smp_valid && !smp_ready) |=> (!run || (smp_valid && $stable(smp_left) && $stable(smp_right)))); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ready) |=> (!run || (mem_req && $stable(mem_addr)))); // R3
  AST_HALF_MOVES_POS: assert property (@(posedge clk) disable iff (!rst_n) half_evt |=> (play_pos != '0)); // R4
  AST_FULL_WRAPS_POS: assert property (@(posedge clk) disable iff (!rst_n) full_evt |=> (play_pos == '0)); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({half_evt, full_evt})); // R4

endmodule

// File: rtl/pcm_pingpong_dma.sv
module pcm_pingpong_dma
  import pcm_dma_pkg::*;
#(
  parameter int AW  = 8,
  parameter int MAW = 32,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic [MAW-1:0] mem_addr,
  input  logic           mem_ready,
  input  logic           mem_rvalid,
  input  logic [31:0]    mem_rdata,
  output logic           smp_valid,
  input  logic           smp_ready,
  output logic [15:0]    smp_left,
  output logic [15:0]    smp_right,
  output logic [31:0]    bclk_rate,
  output logic           irq
);

  localparam int PW = TW + 2;

  logic           wide, mono, run, restart, half_evt, full_evt;
  logic [31:0]    buf_base;
  logic [TW-1:0]  len_code;
  logic [PW-1:0]  play_pos;

  pcm_dma_regs #(.AW(AW), .DW(32), .TW(TW), .PW(PW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_evt(half_evt),
    .full_evt(full_evt), .play_pos(play_pos), .wide(wide), .mono(mono),
    .run(run), .restart(restart), .buf_base(buf_base), .len_code(len_code),
    .irq(irq), .bclk_rate(bclk_rate)
  );

  pcm_dma_fetch #(.MAW(MAW), .TW(TW), .PW(PW)) fetch_i (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .wide(wide),
    .mono(mono), .buf_base(MAW'(buf_base)), .len_code(len_code),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .play_pos(play_pos), .half_evt(half_evt), .full_evt(full_evt)
  );

endmodule

// File: tb/pcm_pingpong_dma_tb_top.sv
`timescale 1ns/1ps
module pcm_pingpong_dma_tb_top;

  localparam logic [31:0] BASE = 32'h0001_10F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic        smp_valid;
  logic        smp_ready = 1'b0;
  logic [15:0] smp_left, smp_right;
  logic [31:0] bclk_rate;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit mem_stall = 1'b0;
  bit snk_free = 1'b0;
  int snk_credits = 0;
  bit pend = 1'b0;
  bit tog = 1'b0;
  logic [31:0] pend_a;
  logic [31:0] mem_log [64];
  logic [15:0] frm_l [64];
  logic [15:0] frm_r [64];
  int mem_n = 0;
  int frm_n = 0;
  int busy_seen = 0;

  pcm_pingpong_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .bclk_rate(bclk_rate), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] memword(input logic [31:0] a);
    logic [7:0] b;
    b = a[7:0];
    return {b + 8'd3, b + 8'd2, b + 8'd1, b};
  endfunction

  // Memory model and frame sink, both acting away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memword(pend_a);
        pend = 1'b0;
      end
      tog = ~tog;
      mem_ready = mem_stall ? tog : 1'b1;
      if (mem_req && mem_ready) begin
        pend = 1'b1;
        pend_a = mem_addr;
        if (mem_n < 64) mem_log[mem_n] = mem_addr;
        mem_n++;
      end
      smp_ready = snk_free || (snk_credits > 0);
      if (smp_valid && smp_ready) begin
        if (frm_n < 64) begin
          frm_l[frm_n] = smp_left;
          frm_r[frm_n] = smp_right;
        end
        frm_n++;
        if (!snk_free) snk_credits--;
      end
      if (mem_req || smp_valid) busy_seen++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (frm_n < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // Bench-side expectation: frame k of a buffer of (len+1) words
  task automatic exp_frame(input int k, input bit wide, input bit mono, input int len,
                           output logic [15:0] l, output logic [15:0] r);
    int per, w, j;
    logic [31:0] a, d;
    per = wide ? (mono ? 2 : 1) : (mono ? 4 : 2);
    w = k / per;
    j = k % per;
    a = BASE + 32'(4 * (w % (len + 1)));
    d = memword(a);
    if (wide && !mono) begin
      l = d[15:0]; r = d[31:16];
    end else if (wide) begin
      l = (j == 0) ? d[15:0] : d[31:16]; r = l;
    end else if (!mono) begin
      l = 16'($signed(d[8*(2*j) +: 8]) * 256);
      r = 16'($signed(d[8*(2*j+1) +: 8]) * 256);
    end else begin
      l = 16'($signed(d[8*j +: 8]) * 256); r = l;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1", "mode after reset", v, 32'h0);
    rd(8'h20, v); chk("R1", "status after reset", v, 32'h0);
    rd(8'h38, v); chk("R1", "position after reset", v, 32'h0);
    chk("R1", "irq after reset", {31'd0, irq}, 32'h0);
    chk("R1", "outputs idle after reset", {30'd0, mem_req, smp_valid}, 32'h0);
    chk("R1", "rate after reset", bclk_rate, 32'd176400);
  endtask

  task automatic t_regs_rate();
    logic [31:0] v;
    wr(8'h18, 32'h0000_0300);
    rd(8'h18, v); chk("R2", "divider readback", v, 32'h0000_0300);
    chk("R10", "rate slow clk div 4", bclk_rate, 32'd44100);
    wr(8'h00, 32'h0000_0200);
    rd(8'h00, v); chk("R2", "mode readback", v, 32'h0000_0200);
    chk("R10", "rate fast clk div 4", bclk_rate, 32'd96000);
    wr(8'h24, 32'h0000_0040);
    rd(8'h24, v); chk("R2", "enable readback", v, 32'h0000_0040);
    wr(8'h2C, 32'h0000_0003);
    rd(8'h2C, v); chk("R2", "length code write-only", v, 32'h0);
    idle(10);
    chk("R11", "no traffic while run low", {31'd0, mem_req | smp_valid}, 32'h0);
    wr(8'h24, 32'h0); wr(8'h00, 32'h0); wr(8'h18, 32'h0);
    chk("R10", "rate back to base", bclk_rate, 32'd176400);
  endtask

  task automatic t_play(input string req, input bit wide, input bit mono, input int len,
                        input int nfr, input bit stall);
    logic [15:0] el, er;
    int bad = 0;
    int bada = 0;
    wr(8'h2C, 32'(len));
    wr(8'h28, {16'h0, BASE[15:0]});
    wr(8'h40, {16'h0, BASE[31:16]});
    mem_stall = stall; snk_free = 1'b1;
    mem_n = 0; frm_n = 0;
    wr(8'h00, (32'd1 << 7) | (wide ? 32'd1 : 32'd0) | (mono ? 32'h4000 : 32'd0));
    wait_frames(nfr);
    wr(8'h00, 32'h0);
    chk(req, "frame count reached", {31'd0, frm_n >= nfr}, 32'h1);
    for (int k = 0; k < nfr && k < 64; k++) begin
      exp_frame(k, wide, mono, len, el, er);
      if (frm_l[k] !== el || frm_r[k] !== er) begin
        if (bad == 0) chk(req, $sformatf("frame %0d", k), {frm_l[k], frm_r[k]}, {el, er});
        bad++;
      end
    end
    if (bad == 0) chk(req, "all frames match", 32'h0, 32'h0);
    for (int i = 0; i < mem_n && i < 2 * (len + 1) && i < 64; i++) begin
      if (mem_log[i] !== BASE + 32'(4 * (i % (len + 1)))) begin
        if (bada == 0) chk("R3", $sformatf("read address %0d", i), mem_log[i], BASE + 32'(4 * (i % (len + 1))));
        bada++;
      end
    end
    if (bada == 0) chk("R3", "read address order", 32'h0, 32'h0);
    mem_stall = 1'b0; snk_free = 1'b0;
    wr(8'h20, 32'h0000_00C0);
  endtask

  task automatic t_pingpong();
    logic [31:0] v;
    wr(8'h2C, 32'd3);
    wr(8'h24, 32'h0);
    snk_free = 1'b0; snk_credits = 0;
    wr(8'h00, 32'h0000_0081);
    idle(10);
    rd(8'h20, v); chk("R4", "no flag before any frame", v, 32'h0);
    snk_credits = 2;
    idle(30);
    rd(8'h20, v); chk("R4", "half flag after first half", v, 32'h0000_0040);
    rd(8'h38, v); chk("R4", "position at second half", v, 32'd2);
    chk("R9", "irq low with enable clear", {31'd0, irq}, 32'h0);
    wr(8'h24, 32'h0000_0040);
    chk("R9", "irq on half enabled", {31'd0, irq}, 32'h1);
    snk_credits = 2;
    idle(30);
    rd(8'h20, v); chk("R4", "both flags after second half", v, 32'h0000_00C0);
    rd(8'h38, v); chk("R4", "position wrapped", v, 32'd0);
    wr(8'h20, 32'h0000_0040);
    rd(8'h20, v); chk("R9", "W1C clears only half", v, 32'h0000_0080);
    chk("R9", "irq low after clear", {31'd0, irq}, 32'h0);
    wr(8'h24, 32'h0000_0080);
    chk("R9", "irq on full enabled", {31'd0, irq}, 32'h1);
    wr(8'h20, 32'h0000_0080);
    chk("R9", "irq low after full clear", {31'd0, irq}, 32'h0);
    wr(8'h00, 32'h0); wr(8'h24, 32'h0);
  endtask

  task automatic t_stop_restart();
    logic [31:0] v;
    int fsave;
    wr(8'h20, 32'h0000_00C0);
    snk_free = 1'b0; snk_credits = 0;
    wr(8'h00, 32'h0000_0081);
    snk_credits = 2;
    idle(30);
    rd(8'h38, v); chk("R11", "position mid buffer before stop", v, 32'd2);
    wr(8'h00, 32'h0000_0001);
    idle(1);
    busy_seen = 0; fsave = frm_n;
    snk_free = 1'b1;
    idle(20);
    chk("R11", "no traffic after stop", 32'(busy_seen), 32'h0);
    chk("R11", "no frames after stop", 32'(frm_n), 32'(fsave));
    mem_n = 0;
    wr(8'h00, 32'h0000_0081);
    idle(10);
    chk("R11", "restart reads from base", mem_log[0], BASE);
    wr(8'h00, 32'h0);
    snk_free = 1'b0;
    wr(8'h20, 32'h0000_00C0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs_rate();
    t_play("R5", 1'b1, 1'b0, 3, 8, 1'b1);
    t_play("R6", 1'b1, 1'b1, 3, 8, 1'b0);
    t_play("R7", 1'b0, 1'b0, 7, 16, 1'b1);
    t_play("R8", 1'b0, 1'b1, 7, 32, 1'b0);
    t_pingpong();
    t_stop_restart();
    finish_run();
  end

endmodule